// File: doc/BRIEF.md
# Card Socket Power Sequencer

This block drives the supply selection and the reset line of a removable card socket. When it accepts an enable request it runs a fixed timed sequence. It first drives both supply selects to their 0 V codes and holds them for a power-off dwell. It then waits a fall dwell so the supply can decay. Next it selects 5 V on Vcc, with Vpp kept at 0 V, and waits a rise-and-settle dwell. It then pulses the card reset line and waits a recovery dwell before it reports completion. A disable request, or a card-removal event, cuts the power, holds it off for the power-off dwell and then waits a decay dwell.

Every dwell is a cycle count. By default each count is derived from a clock-frequency parameter: 20 ms power-off, 400 ms fall (300 ms decay plus 100 ms for the Vcc change), 420 ms rise and settle, 10 µs reset, 20 ms recovery and 300 ms decay on disable. An integrator or a bench can override any count directly. A disable or a removal aborts an enable sequence at once. The block raises `busy` for the whole of a sequence and gives a one-cycle `done` pulse when the sequence ends. The analog power switch that decodes the select codes sits outside this block.

Top module: `sock_pwr_seq`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `vccSel` = 2'b00 (0 V), `vppSel` = 2'b00 (0 V), `cardRst` = 0, `busy` = 0 and `done` = 0. Asserting reset in the middle of a sequence returns all outputs to these values.
- R2: An enable request accepted in idle starts the power-off phase in the next cycle. `vccSel` and `vppSel` are 2'b00 for OFF_CYC cycles and then for a further FALL_CYC cycles.
- R3: After the fall phase, `vccSel` becomes 2'b01 (5 V) while `vppSel` stays 2'b00. The sequence then waits RISE_CYC cycles.
- R4: `cardRst` is high for exactly RST_CYC cycles, immediately after the rise phase. It is high only while `vccSel` is 2'b01, and it is low in every other state.
- R5: After the reset pulse the block waits RECOV_CYC cycles, then ends the sequence. `vccSel` stays 2'b01 in idle afterwards.
- R6: A disable request accepted in idle drives `vccSel` and `vppSel` to 2'b00 in the next cycle. The block then stays busy for OFF_CYC + DFALL_CYC cycles.
- R7: A one-cycle `cardRemoved` pulse starts exactly the same sequence as a disable request.
- R8: A disable request or a removal during an enable sequence aborts that sequence. In the next cycle Vcc is at 0 V and `cardRst` is low, and a complete disable sequence follows. The aborted enable gives no `done`.
- R9: While a sequence is running, an enable request is ignored, and so is a disable or removal request during a disable sequence. When enable and disable arrive together in idle, the disable sequence runs.
- R10: `busy` rises in the cycle after a request is accepted and stays high until the sequence ends. `done` is high for exactly one cycle, and that is the cycle in which `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enReq | input | 1 | Request to power up and reset the socket |
| disReq | input | 1 | Request to power down the socket |
| cardRemoved | input | 1 | Card-removal event; starts power-down |
| vccSel | output | 2 | Vcc select: 00 = 0 V, 01 = 5 V |
| vppSel | output | 2 | Vpp select: 00 = 0 V |
| cardRst | output | 1 | Card reset line, active high |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
All outputs are registered, so a request sampled at one clock edge shows its first effect in the cycle after that edge. A dwell of N cycles therefore holds its output values for exactly N sampled cycles. The bench drives each request for one cycle between edges and then samples every following cycle at the falling edge. It compares `busy`, `done`, `cardRst` and `vccSel` with a per-cycle expectation computed from the shortened dwell counts. An enable sequence is checked cycle by cycle over its 29 busy cycles plus the done cycle and a few idle cycles. An abort is injected at a chosen cycle index, and the bench then expects the disable trace to start in the very next sampled cycle.

// File: rtl/sps_pkg.sv
package sps_pkg;

  localparam logic [1:0] VCC_0V = 2'b00;
  localparam logic [1:0] VCC_5V = 2'b01;
  localparam logic [1:0] VPP_0V = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EN_OFF, ST_EN_FALL, ST_EN_RISE,
    ST_EN_RST, ST_EN_RECOV, ST_DIS_OFF, ST_DIS_FALL
  } seqState_e;

  typedef enum logic [2:0] {
    PH_OFF, PH_FALL, PH_RISE, PH_RST, PH_RECOV, PH_DFALL
  } phase_e;

  typedef struct packed {
    logic   load;
    phase_e phase;
    logic   pwrUp;
    logic   pwrDown;
    logic   rstOn;
    logic   finish;
  } seqStrobe_t;

endpackage

// File: rtl/sps_ctrl.sv
module sps_ctrl
  import sps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enReq,
  input  logic       disReq,
  input  logic       cardRemoved,
  input  logic       expire,
  output seqStrobe_t strobe,
  output logic       busy
);

  seqState_e state, nxt;
  logic stopReq;

  assign stopReq = disReq | cardRemoved;

  always_comb begin
    nxt          = state;
    strobe.load  = 1'b0;
    strobe.phase = PH_OFF;
    strobe.finish = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (stopReq) begin
          nxt = ST_DIS_OFF; strobe.load = 1'b1; strobe.phase = PH_OFF;
        end else if (enReq) begin
          nxt = ST_EN_OFF; strobe.load = 1'b1; strobe.phase = PH_OFF;
        end
      end
      ST_EN_OFF, ST_EN_FALL, ST_EN_RISE, ST_EN_RST, ST_EN_RECOV: begin
        if (stopReq) begin
          nxt = ST_DIS_OFF; strobe.load = 1'b1; strobe.phase = PH_OFF;
        end else if (expire) begin
          strobe.load = 1'b1;
          case (state)
            ST_EN_OFF:  begin nxt = ST_EN_FALL;  strobe.phase = PH_FALL;  end
            ST_EN_FALL: begin nxt = ST_EN_RISE;  strobe.phase = PH_RISE;  end
            ST_EN_RISE: begin nxt = ST_EN_RST;   strobe.phase = PH_RST;   end
            ST_EN_RST:  begin nxt = ST_EN_RECOV; strobe.phase = PH_RECOV; end
            default: begin
              nxt = ST_IDLE; strobe.load = 1'b0; strobe.finish = 1'b1;
            end
          endcase
        end
      end
      ST_DIS_OFF: begin
        if (expire) begin
          nxt = ST_DIS_FALL; strobe.load = 1'b1; strobe.phase = PH_DFALL;
        end
      end
      default: begin
        if (expire) begin
          nxt = ST_IDLE; strobe.finish = 1'b1;
        end
      end
    endcase
  end

  assign strobe.pwrUp   = strobe.load && (strobe.phase == PH_RISE);
  assign strobe.pwrDown = strobe.load && (strobe.phase == PH_OFF);
  assign strobe.rstOn   = (nxt == ST_EN_RST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sps_dpath.sv
module sps_dpath
  import sps_pkg::*;
#(
  parameter int OFF_CYC   = 1000,
  parameter int FALL_CYC  = 1000,
  parameter int RISE_CYC  = 1000,
  parameter int RST_CYC   = 10,
  parameter int RECOV_CYC = 1000,
  parameter int DFALL_CYC = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output logic       expire,
  output logic [1:0] vccSel,
  output logic [1:0] vppSel,
  output logic       cardRst,
  output logic       done
);

  localparam int MAX_A  = (OFF_CYC > FALL_CYC) ? OFF_CYC : FALL_CYC;
  localparam int MAX_B  = (RISE_CYC > RST_CYC) ? RISE_CYC : RST_CYC;
  localparam int MAX_C  = (RECOV_CYC > DFALL_CYC) ? RECOV_CYC : DFALL_CYC;
  localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_ALL = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CW = $clog2(MAX_ALL + 1);

  logic [CW-1:0] cnt, loadVal;

  always_comb begin
    case (strobe.phase)
      PH_OFF:   loadVal = CW'(OFF_CYC - 1);
      PH_FALL:  loadVal = CW'(FALL_CYC - 1);
      PH_RISE:  loadVal = CW'(RISE_CYC - 1);
      PH_RST:   loadVal = CW'(RST_CYC - 1);
      PH_RECOV: loadVal = CW'(RECOV_CYC - 1);
      default:  loadVal = CW'(DFALL_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      vccSel  <= VCC_0V;
      cardRst <= 1'b0;
      done    <= 1'b0;
    end else begin
      if (strobe.load)   cnt <= loadVal;
      else if (cnt != 0) cnt <= cnt - 1'b1;
      if (strobe.pwrDown)    vccSel <= VCC_0V;
      else if (strobe.pwrUp) vccSel <= VCC_5V;
      cardRst <= strobe.rstOn;
      done    <= strobe.finish;
    end
  end

  assign expire = (cnt == '0);
  assign vppSel = VPP_0V;

endmodule

// File: rtl/sock_pwr_seq.sv
module sock_pwr_seq
  import sps_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int OFF_CYC   = CLK_HZ / 1000 * 20,
  parameter int FALL_CYC  = CLK_HZ / 1000 * 400,
  parameter int RISE_CYC  = CLK_HZ / 1000 * 420,
  parameter int RST_CYC   = CLK_HZ / 100_000,
  parameter int RECOV_CYC = CLK_HZ / 1000 * 20,
  parameter int DFALL_CYC = CLK_HZ / 1000 * 300
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enReq,
  input  logic       disReq,
  input  logic       cardRemoved,
  output logic [1:0] vccSel,
  output logic [1:0] vppSel,
  output logic       cardRst,
  output logic       busy,
  output logic       done
);

  seqStrobe_t strobe;
  logic expire;

  sps_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enReq(enReq), .disReq(disReq),
    .cardRemoved(cardRemoved), .expire(expire), .strobe(strobe), .busy(busy)
  );

  sps_dpath #(
    .OFF_CYC(OFF_CYC), .FALL_CYC(FALL_CYC), .RISE_CYC(RISE_CYC),
    .RST_CYC(RST_CYC), .RECOV_CYC(RECOV_CYC), .DFALL_CYC(DFALL_CYC)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .expire(expire),
    .vccSel(vccSel), .vppSel(vppSel), .cardRst(cardRst), .done(done)
  );

endmodule

// File: rtl/sps_chk.sv
module sps_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enReq,
  input logic       disReq,
  input logic       cardRemoved,
  input logic [1:0] vccSel,
  input logic [1:0] vppSel,
  input logic       cardRst,
  input logic       busy,
  input logic       done
);

  logic unusedVpp;
  assign unusedVpp = ^vppSel;

  AST_RST_NEEDS_VCC: assert property (@(posedge clk) disable iff (!rstN)
    cardRst |-> vccSel == 2'b01); // R4
  AST_RST_AFTER_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardRst) |-> $past(vccSel) == 2'b01); // R4
  AST_IDLE_NO_RST: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cardRst); // R4
  AST_STOP_CUTS_POWER: assert property (@(posedge clk) disable iff (!rstN)
    (disReq || cardRemoved) |=> (vccSel == 2'b00) && !cardRst); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy)); // R10
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (enReq || disReq || cardRemoved)) |=> busy); // R10

endmodule

bind sock_pwr_seq sps_chk u_chk (.*);

// File: tb/sock_pwr_seq_bench.sv
module sock_pwr_seq_bench;

  localparam int TOFF = 5, TFALL = 8, TRISE = 9, TRST = 3, TRECOV = 4, TDFALL = 6;
  localparam int RISE_AT  = TOFF + TFALL;
  localparam int RST_AT   = RISE_AT + TRISE;
  localparam int RECOV_AT = RST_AT + TRST;
  localparam int EN_LEN   = RECOV_AT + TRECOV;
  localparam int DIS_LEN  = TOFF + TDFALL;

  logic clk = 1'b0, rstN = 1'b0;
  logic enReq = 1'b0, disReq = 1'b0, cardRemoved = 1'b0;
  logic [1:0] vccSel, vppSel;
  logic cardRst, busy, done;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sock_pwr_seq #(
    .CLK_HZ(50_000_000), .OFF_CYC(TOFF), .FALL_CYC(TFALL), .RISE_CYC(TRISE),
    .RST_CYC(TRST), .RECOV_CYC(TRECOV), .DFALL_CYC(TDFALL)
  ) u_sock_pwr_seq (
    .clk(clk), .rstN(rstN), .enReq(enReq), .disReq(disReq),
    .cardRemoved(cardRemoved), .vccSel(vccSel), .vppSel(vppSel),
    .cardRst(cardRst), .busy(busy), .done(done)
  );

  // packed view {busy, done, cardRst, vccSel[1:0]}
  function automatic logic [4:0] expEn(int k);
    logic b, d, r; logic [1:0] v;
    b = (k < EN_LEN);
    d = (k == EN_LEN);
    r = (k >= RST_AT) && (k < RECOV_AT);
    v = (k >= RISE_AT) ? 2'b01 : 2'b00;
    return {b, d, r, v};
  endfunction

  function automatic logic [4:0] expDis(int j);
    return {(j < DIS_LEN), (j == DIS_LEN), 1'b0, 2'b00};
  endfunction

  function automatic string enTag(int k);
    if (k < RISE_AT)  return "R2";
    if (k < RST_AT)   return "R3";
    if (k < RECOV_AT) return "R4";
    if (k < EN_LEN)   return "R5";
    return "R10";
  endfunction

  task automatic check(string req, int k, logic [4:0] exp);
    logic [4:0] got;
    got = {busy, done, cardRst, vccSel};
    nChecks++;
    if (got !== exp || vppSel !== 2'b00) begin
      nFails++;
      $display("FAIL %s cycle %0d: {busy,done,rst,vcc}=%b vpp=%b expected %b vpp=00",
               req, k, got, vppSel, exp);
    end
  endtask

  // one-cycle input pulse, sets at a falling edge and clears at the next
  task automatic pulse(logic en, logic dis, logic rem);
    enReq = en; disReq = dis; cardRemoved = rem;
    @(negedge clk);
    enReq = 1'b0; disReq = 1'b0; cardRemoved = 1'b0;
  endtask

  task automatic testReset();
    check("R1 in reset", 0, 5'b00000);
    @(negedge clk); rstN = 1'b1;
    check("R1 after release", 0, 5'b00000);
    @(negedge clk);
  endtask

  task automatic testEnable(int reqAgainAt);
    pulse(1'b1, 1'b0, 1'b0);
    for (int k = 0; k <= EN_LEN + 2; k++) begin
      check(reqAgainAt >= 0 ? "R9 enable ignored" : enTag(k), k, expEn(k));
      if (k == reqAgainAt) pulse(1'b1, 1'b0, 1'b0);
      else @(negedge clk);
    end
  endtask

  task automatic testDisable(bit useRemove, int againAt, string req);
    pulse(1'b0, !useRemove, useRemove);
    for (int j = 0; j <= DIS_LEN + 2; j++) begin
      check(j == DIS_LEN ? "R10" : req, j, expDis(j));
      if (j == againAt) pulse(1'b1, 1'b1, 1'b1);
      else @(negedge clk);
    end
  endtask

  task automatic testAbort(int at, bit useRemove);
    pulse(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < at; k++) begin
      check(enTag(k), k, expEn(k));
      if (k == at - 1) pulse(1'b0, !useRemove, useRemove);
      else @(negedge clk);
    end
    for (int j = 0; j <= DIS_LEN + 1; j++) begin
      check(useRemove ? "R8 removal abort" : "R8 disable abort", j, expDis(j));
      @(negedge clk);
    end
  endtask

  task automatic testBoth();
    pulse(1'b1, 1'b1, 1'b0);
    for (int j = 0; j <= DIS_LEN + 1; j++) begin
      check("R9 simultaneous", j, expDis(j));
      @(negedge clk);
    end
  endtask

  task automatic testMidReset();
    pulse(1'b1, 1'b0, 1'b0);
    repeat (RST_AT + 1) @(negedge clk);
    check("R4 reset pulse live", 0, expEn(RST_AT + 1));
    rstN = 1'b0;
    #1;
    check("R1 mid reset", 0, 5'b00000);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 1, 5'b00000);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testEnable(-1);          // full enable, R2..R5, R10
    testDisable(1'b0, -1, "R6");
    testEnable(-1);
    testDisable(1'b1, -1, "R7");
    testEnable(10);          // second enable while busy
    testDisable(1'b0, 4, "R9 requests ignored");
    testAbort(RISE_AT + 3, 1'b0);
    testAbort(RST_AT + 2, 1'b1);
    testBoth();
    testMidReset();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule